// File: doc/BRIEF.md
# Per-Channel Interrupt Flags with Capture Overrun Tracking

This block holds the interrupt flags for a set of timer channels. Each channel takes three single-cycle event pulses: an input capture, a compare match and a timebase overflow. The overflow pulse is shared by every channel. Each event sets its own flag, and software clears a flag by writing 1 to its bit. Each flag is ANDed with a mask bit, and the masked flags are ORed onto one registered interrupt line per channel. The compare event also drives a second, unmasked interrupt line per channel.

The capture flag is a three-state machine so that software can tell when it has missed captures. The states are CAP_IDLE, CAP_PEND and CAP_OVR. The transitions are:
- idle_to_pend: a capture event arrives in CAP_IDLE.
- pend_to_ovr: a capture event arrives in CAP_PEND.
- ovr_hold: a capture event arrives in CAP_OVR.
- ovr_to_pend: a write-1 to the capture bit arrives in CAP_OVR with no capture event.
- pend_to_idle: a write-1 to the capture bit arrives in CAP_PEND with no capture event.

In CAP_OVR, software therefore needs two separate clearing writes to get the flag back to idle. A read-only overrun bit shows when the machine is in CAP_OVR.

Software reaches two registers per channel through a flat address. Address bit 0 selects the register: 0 for the flag register, 1 for the mask register. The upper address bits select the channel.

Top module: `irqf_top`

## Requirements
- R1: After reset, all flags and all mask bits are 0, both interrupt vectors are 0, and every register reads 0.
- R2: Compare flag (flag register bit 1) and overflow flag (bit 2) are set by their event in the cycle after the event edge. A write with 1 in that bit clears the flag. A write with 0 in that bit leaves it unchanged.
- R3: A capture event in CAP_IDLE moves the channel to CAP_PEND. Flag register bit 0 then reads 1 and bit 3 reads 0.
- R4: A capture event in CAP_PEND moves the channel to CAP_OVR. Bit 0 and the overrun bit 3 then both read 1. A capture event in CAP_OVR keeps it there.
- R5: A write with bit 0 set moves CAP_OVR to CAP_PEND and CAP_PEND to CAP_IDLE. In CAP_IDLE it has no effect.
- R6: When an event and a clearing write for the same flag land in the same cycle, the event wins: the flag is set, or the capture machine advances.
- R7: `irq_or[i]` equals the OR of channel i's flags ANDed with its mask bits (mask bit 0 capture, bit 1 compare, bit 2 overflow), sampled one clock earlier.
- R8: `irq_cmp[i]` is high for exactly the one cycle after a compare event on channel i, whatever the mask.
- R9: The mask register holds bits 2:0 as written and reads 0 in bit 3. Writes to flag register bit 3 have no effect.
- R10: The shared overflow event sets the overflow flag in every channel.
- R11: A write acts only on the channel and register its address selects.
- R12: Addresses whose channel field is at or above NUM_CH read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_evt | input | NUM_CH | Capture event pulse per channel |
| cmp_evt | input | NUM_CH | Compare match pulse per channel |
| ovf_evt | input | 1 | Timebase overflow pulse, shared by all channels |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | {channel, register select}; bit 0 = 1 selects the mask register |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Read data for addr, combinational |
| irq_or | output | NUM_CH | Registered masked OR interrupt per channel |
| irq_cmp | output | NUM_CH | Registered unmasked compare interrupt per channel |

## Verification
The bench builds the block with NUM_CH = 3. The channel field is then two bits wide, and address 6 or 7 names a channel that does not exist, which brings the R12 decode within reach. Three channels are also enough to show that a write to one channel leaves its neighbours unchanged while the shared overflow pulse reaches all of them. Random capture and clear traffic with a fixed seed drives the capture machine through every transition, including same-cycle event and clear collisions.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_PEND = 2'd1,
        CAP_OVR  = 2'd2
    } cap_state_t;

    localparam int BIT_CAP = 0;
    localparam int BIT_CMP = 1;
    localparam int BIT_OVF = 2;
    localparam int BIT_OVR = 3;
    localparam int REG_W   = 4;
endpackage

// File: rtl/irqf_cap_fsm.sv
module irqf_cap_fsm
    import irqf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_evt,
    input  logic clr_wr,
    output logic pending,
    output logic overrun
);
    cap_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CAP_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CAP_IDLE: if (cap_evt) st_d = CAP_PEND;
            CAP_PEND: begin
                if (cap_evt)     st_d = CAP_OVR;
                else if (clr_wr) st_d = CAP_IDLE;
            end
            CAP_OVR: if (!cap_evt && clr_wr) st_d = CAP_PEND;
            default: st_d = CAP_IDLE;
        endcase
    end

    always_comb begin
        pending = (st_q != CAP_IDLE);
        overrun = (st_q == CAP_OVR);
    end

    assert_ovr_needs_evt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != CAP_OVR && !cap_evt) |=> (st_q != CAP_OVR));
    assert_ovr_single_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CAP_OVR && clr_wr && !cap_evt) |=> (st_q == CAP_PEND));
    assert_evt_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (st_q != CAP_IDLE));
endmodule

// File: rtl/irqf_flag.sv
module irqf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_wr,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= 1'b0;
        else if (set_evt) q <= 1'b1;
        else if (clr_wr)  q <= 1'b0;
    end

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> q);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_evt && !clr_wr) |=> $stable(q));
endmodule

// File: rtl/irqf_channel.sv
module irqf_channel
    import irqf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_evt,
    input  logic             cmp_evt,
    input  logic             ovf_evt,
    input  logic             flag_wr,
    input  logic             mask_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] flag_rd,
    output logic [REG_W-1:0] mask_rd,
    output logic             irq_or,
    output logic             irq_cmp
);
    logic       cap_pend, cap_ovr, cmp_q, ovf_q;
    logic [2:0] mask_q;
    logic [2:0] flags;

    irqf_cap_fsm u_cap (
        .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt),
        .clr_wr(flag_wr && wdata[BIT_CAP]),
        .pending(cap_pend), .overrun(cap_ovr)
    );

    irqf_flag u_cmp (
        .clk(clk), .rst_n(rst_n), .set_evt(cmp_evt),
        .clr_wr(flag_wr && wdata[BIT_CMP]), .q(cmp_q)
    );

    irqf_flag u_ovf (
        .clk(clk), .rst_n(rst_n), .set_evt(ovf_evt),
        .clr_wr(flag_wr && wdata[BIT_OVF]), .q(ovf_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= wdata[2:0];
    end

    always_comb begin
        flags   = {ovf_q, cmp_q, cap_pend};
        flag_rd = {cap_ovr, flags};
        mask_rd = {1'b0, mask_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_or  <= 1'b0;
            irq_cmp <= 1'b0;
        end else begin
            irq_or  <= |(flags & mask_q);
            irq_cmp <= cmp_evt;
        end
    end

    assert_or_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|(flags & mask_q))) |=> !irq_or);
    assert_cmp_direct_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_evt |=> irq_cmp);
    assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask_q));
endmodule

// File: rtl/irqf_top.sv
module irqf_top
    import irqf_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] cap_evt,
    input  logic [NUM_CH-1:0] cmp_evt,
    input  logic              ovf_evt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [NUM_CH-1:0] irq_or,
    output logic [NUM_CH-1:0] irq_cmp
);
    logic [CH_W-1:0]  ch_sel;
    logic             reg_sel;
    logic [REG_W-1:0] flag_rd [NUM_CH];
    logic [REG_W-1:0] mask_rd [NUM_CH];

    assign ch_sel  = addr[ADDR_W-1:1];
    assign reg_sel = addr[0];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = wr_en && (ch_sel == CH_W'(i));
        irqf_channel u_ch (
            .clk(clk), .rst_n(rst_n),
            .cap_evt(cap_evt[i]), .cmp_evt(cmp_evt[i]), .ovf_evt(ovf_evt),
            .flag_wr(hit && !reg_sel), .mask_wr(hit && reg_sel),
            .wdata(wdata), .flag_rd(flag_rd[i]), .mask_rd(mask_rd[i]),
            .irq_or(irq_or[i]), .irq_cmp(irq_cmp[i])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_sel == CH_W'(i)) rdata = reg_sel ? mask_rd[i] : flag_rd[i];
        end
    end
endmodule

// File: tb/irqf_top_tb.sv
module irqf_top_tb;
    localparam int N  = 3;
    localparam int CW = 2;
    localparam int AW = CW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  cap_evt = '0, cmp_evt = '0;
    logic          ovf_evt = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [3:0]    wdata = '0, rdata;
    logic [N-1:0]  irq_or, irq_cmp;

    always #2.5 clk = ~clk;

    irqf_top #(.NUM_CH(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .cmp_evt(cmp_evt),
        .ovf_evt(ovf_evt), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_or(irq_or), .irq_cmp(irq_cmp)
    );

    int tests = 0, fails = 0;
    bit done = 0;
    int m_cap [N];
    bit m_cmp [N];
    bit m_ovf [N];
    bit [2:0] m_mask [N];
    logic [N-1:0] e_or = '0, e_cmp = '0;

    function automatic logic [3:0] model_read(input logic [AW-1:0] a);
        int ch = int'(a[AW-1:1]);
        if (ch >= N) return 4'h0;
        if (a[0]) return {1'b0, m_mask[ch]};
        return {m_cap[ch] == 2, m_ovf[ch], m_cmp[ch], m_cap[ch] != 0};
    endfunction

    function automatic string tag_for(input logic [AW-1:0] a);
        if (int'(a[AW-1:1]) >= N) return "R12";
        if (a[0]) return "R9 R11";
        return "R2 R3 R4 R5 R6 R10 R11";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        for (int i = 0; i < N; i++) begin
            bit hit = wr_en && (int'(addr[AW-1:1]) == i);
            bit fw = hit && !addr[0];
            e_or[i]  = |({m_ovf[i], m_cmp[i], m_cap[i] != 0} & m_mask[i]);
            e_cmp[i] = cmp_evt[i];
            if (cap_evt[i])            m_cap[i] = (m_cap[i] == 0) ? 1 : 2;
            else if (fw && wdata[0])   m_cap[i] = (m_cap[i] == 2) ? 1 : 0;
            if (cmp_evt[i])            m_cmp[i] = 1;
            else if (fw && wdata[1])   m_cmp[i] = 0;
            if (ovf_evt)               m_ovf[i] = 1;
            else if (fw && wdata[2])   m_ovf[i] = 0;
            if (hit && addr[0])        m_mask[i] = wdata[2:0];
        end
    endtask

    task automatic step(input logic [N-1:0] cp, input logic [N-1:0] cm, input logic ov,
                        input logic we, input logic [AW-1:0] a, input logic [3:0] d);
        cap_evt = cp; cmp_evt = cm; ovf_evt = ov; wr_en = we; addr = a; wdata = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("R7 irq_or", 32'(irq_or), 32'(e_or));
        check("R8 irq_cmp", 32'(irq_cmp), 32'(e_cmp));
        check(tag_for(a), 32'(rdata), 32'(model_read(a)));
    endtask

    task automatic idle_read(input logic [AW-1:0] a);
        step('0, '0, 1'b0, 1'b0, a, 4'h0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_cap[i] = 0; m_cmp[i] = 0; m_ovf[i] = 0; m_mask[i] = '0;
        end
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state seen through every address
        for (int a = 0; a < (1 << AW); a++) begin
            addr = AW'(a);
            #1 check("R1 reset read", 32'(rdata), 32'h0);
        end
        check("R1 reset irq", 32'({irq_or, irq_cmp}), 32'h0);

        // Directed: capture overrun and two-step clear on channel 1 (R4 R5)
        step(3'b010, '0, 1'b0, 1'b0, 3'd2, 4'h0);
        step(3'b010, '0, 1'b0, 1'b0, 3'd2, 4'h0);
        step('0, '0, 1'b0, 1'b1, 3'd2, 4'h1);
        idle_read(3'd2);
        step('0, '0, 1'b0, 1'b1, 3'd2, 4'h1);
        idle_read(3'd2);
        // R6: event and clear collide
        step(3'b010, 3'b010, 1'b1, 1'b1, 3'd2, 4'h7);
        // R9: flag bit3 write ignored, mask write/read
        step('0, '0, 1'b0, 1'b1, 3'd2, 4'h8);
        step('0, '0, 1'b0, 1'b1, 3'd3, 4'hF);
        idle_read(3'd3);
        idle_read(3'd0);
        // R12: out-of-range channel
        step('0, '0, 1'b0, 1'b1, 3'd6, 4'hF);
        step('0, '0, 1'b0, 1'b1, 3'd7, 4'hF);
        idle_read(3'd7);

        // Random traffic
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] cp, cm;
            for (int i = 0; i < N; i++) begin
                cp[i] = ($urandom % 4) == 0;
                cm[i] = ($urandom % 6) == 0;
            end
            step(cp, cm, ($urandom % 10) == 0, ($urandom % 3) != 0,
                 AW'($urandom), 4'($urandom));
        end

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule